// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block links a single-beat host request port to an asynchronous DRAM with fast page mode and a shared row/column address bus. A host request carries one address, a write flag and write data. The controller splits the address into a row and a column. It drives the row/column strobes, the write strobe and the output enable, and it returns read data with a one-clock valid pulse. After a column access the row is left open, so a later request to the same row cycles only the column strobe. A request to a different row closes the page first.

The controller handles the part's housekeeping itself. After reset it waits out the power-on pause and then issues a series of wake-up cycles. After that it keeps an interval timer that requests one column-before-row refresh per interval. Refreshes that come due while the controller is busy are counted, up to a bound. Every timing limit is a count of clock cycles derived from the clock period parameter and the part's nanosecond timings. The bidirectional data pins appear as separate in, out and drive-enable signals. The address pins are `ROW_W` wide and `COL_W` must not exceed `ROW_W`. A host address is `{row, column}`, with the column in the low `COL_W` bits.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: From reset release until `INIT_US` microseconds have elapsed, both strobes stay high and `ready` stays low.
- R2: After that pause, exactly `WAKE_CYCLES` (8) refresh-type cycles are issued before `ready` first rises, and no row is activated before `ready` rises.
- R3: On a row activation, `dram_a` carries the row (host address bits above `COL_W`) when the row strobe falls. When the column strobe falls, `dram_a` carries the column (low `COL_W` bits, zero-extended).
- R4: For a write, the write strobe is low and `dq_oe` drives the request's data before the column strobe falls, and that data is stored at the addressed cell.
- R5: For a read, the write strobe is high and the output enable is low at the column strobe fall. The data is sampled only after tRAC, tAA and tCAC have all elapsed. It appears on `rdata` with `rvalid` high for exactly one clock per read.
- R6: A request to the row that is already open causes no new row strobe fall.
- R7: The row strobe stays low for at least tRAS. It stays high for at least tRP between cycles, and successive falls are at least tRC apart. Every request to a different row reactivates that row, and `ready` is low in the cycle after such a request is accepted.
- R8: One refresh becomes due every `(REF_ROWS==4096 ? 64 ms : 32 ms) / REF_ROWS`. A refresh cycle lowers the column strobe before the row strobe, drives no data, keeps the output enable high, and occurs while `ready` is low.
- R9: A refresh that falls due with a page open closes the page (row strobe high) before the refresh. The next request to that row reactivates it with its data intact.
- R10: Between two column accesses in one page, the column strobe stays high for at least tCP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_NS` |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | `{row, column}` |
| wdata | input | DQ_W | Write data |
| ready | output | 1 | Controller can take a request this cycle |
| rdata | output | DQ_W | Read data |
| rvalid | output | 1 | One-clock pulse marking `rdata` |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | ROW_W | Multiplexed row/column address |
| dq_out | output | DQ_W | Data driven toward the DRAM |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | DQ_W | Data returned by the DRAM |

## Verification
The embedded assertions check the local rules on every cycle:
- the minimum row strobe low time;
- the column strobe leading the row strobe in refresh;
- write data being driven before the column strobe falls;
- the single-cycle read valid pulse;
- silence on the data pins during initialisation;
- the bound on pending refreshes.

The bench's scenarios cover what needs history or a memory model. Its behavioural DRAM returns corrupted data until every access time has passed. It measures the precharge, cycle and column precharge times in nanoseconds. It counts row activations to show page hits and misses, and it times the refresh rate over a long idle window.

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
module fpm_dram_ctrl #(
  parameter int CLK_NS      = 10,
  parameter int ROW_W       = 12,
  parameter int COL_W       = 10,
  parameter int DQ_W        = 4,
  parameter int INIT_US     = 200,
  parameter int WAKE_CYCLES = 8,
  parameter int REF_ROWS    = 4096,
  parameter int MAX_PEND    = 8,
  parameter int TRAC_NS     = 50,
  parameter int TCAC_NS     = 13,
  parameter int TAA_NS      = 25,
  parameter int TRAS_NS     = 50,
  parameter int TRC_NS      = 84,
  parameter int TRP_NS      = 30,
  parameter int TCP_NS      = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [DQ_W-1:0]        wdata,
  output logic                   ready,
  output logic [DQ_W-1:0]        rdata,
  output logic                   rvalid,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_a,
  output logic [DQ_W-1:0]        dq_out,
  output logic                   dq_oe,
  input  logic [DQ_W-1:0]        dq_in
);
  localparam int AW       = ROW_W + COL_W;
  localparam int COLA_T   = (TCP_NS + CLK_NS - 1) / CLK_NS;
  localparam int COLA_CYC = (COLA_T < 1) ? 1 : COLA_T;
  localparam int CAS_A    = TAA_NS / CLK_NS + 1 - COLA_CYC;
  localparam int CAS_C    = TCAC_NS / CLK_NS + 1;
  localparam int CAS_M    = (CAS_A > CAS_C) ? CAS_A : CAS_C;
  localparam int CAS_CYC  = (CAS_M < 1) ? 1 : CAS_M;
  localparam int ROW_T    = TRAC_NS / CLK_NS + 1 - COLA_CYC - CAS_CYC;
  localparam int ROW_CYC  = (ROW_T < 1) ? 1 : ROW_T;
  localparam int RP_T     = (TRP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP_CYC   = (RP_T < 1) ? 1 : RP_T;
  localparam int RAS_A    = (TRAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_B    = (TRC_NS + CLK_NS - 1) / CLK_NS - RP_CYC;
  localparam int RAS_M    = (RAS_A > RAS_B) ? RAS_A : RAS_B;
  localparam int RAS_CYC  = (RAS_M < 2) ? 2 : RAS_M;
  localparam int INIT_CYC = INIT_US * 1000 / CLK_NS;
  localparam int REF_MS   = (REF_ROWS >= 4096) ? 64 : 32;
  localparam int REF_CYC  = REF_MS * 1000000 / (REF_ROWS * CLK_NS);
  localparam int TW       = $clog2(INIT_CYC + RAS_CYC + 64);
  localparam int RCW      = $clog2(RAS_CYC + 1);
  localparam int RFW      = $clog2(REF_CYC + 1);
  localparam int PW       = $clog2(MAX_PEND + 1);
  localparam int WW       = $clog2(WAKE_CYCLES + 1);

  typedef enum logic [3:0] {
    S_PWR, S_IDLE, S_ACT, S_COLA, S_CAS, S_PAGE, S_CLOSE, S_PRE, S_REFC, S_REFR
  } st_t;

  st_t              st, nx;
  logic [TW-1:0]    tmr;
  logic [RCW-1:0]   ras_cnt;
  logic [RFW-1:0]   ref_tmr;
  logic [PW-1:0]    pend;
  logic [WW-1:0]    wake;
  logic             initd, op_pend, op_we;
  logic [ROW_W-1:0] op_row;
  logic [COL_W-1:0] op_col;
  logic [DQ_W-1:0]  op_wd;
  logic             ref_due, accept, row_hit, ras_ok, col_ph, cas_end, ref_end, tick;

  assign ref_due = pend != '0;
  assign ready   = initd && (st == S_IDLE || st == S_PAGE) && !ref_due;
  assign accept  = req && ready;
  assign row_hit = addr[AW-1:COL_W] == op_row;
  assign ras_ok  = ras_cnt >= RCW'(RAS_CYC - 1);
  assign col_ph  = st == S_COLA || st == S_CAS;
  assign cas_end = st == S_CAS && nx == S_PAGE;
  assign ref_end = st == S_REFR && nx == S_PRE;
  assign tick    = initd && ref_tmr == RFW'(REF_CYC - 1);

  assign dram_ras_n = !(st == S_ACT || col_ph || st == S_PAGE || st == S_CLOSE || st == S_REFR);
  assign dram_cas_n = !(st == S_CAS || st == S_REFC || st == S_REFR);
  assign dram_we_n  = !(op_we && col_ph);
  assign dram_oe_n  = !(!op_we && col_ph);
  assign dq_oe      = op_we && col_ph;
  assign dq_out     = op_wd;
  assign dram_a     = col_ph ? ROW_W'(op_col) : op_row;

  always_comb begin
    nx = st;
    unique case (st)
      S_PWR:   if (tmr == TW'(INIT_CYC - 1)) nx = S_REFC;
      S_IDLE:  if (ref_due) nx = S_REFC; else if (accept) nx = S_ACT;
      S_ACT:   if (tmr == TW'(ROW_CYC - 1)) nx = S_COLA;
      S_COLA:  if (tmr == TW'(COLA_CYC - 1)) nx = S_CAS;
      S_CAS:   if (tmr == TW'(CAS_CYC - 1)) nx = S_PAGE;
      S_PAGE:  if (accept) nx = row_hit ? S_COLA : S_CLOSE;
               else if (ref_due) nx = S_CLOSE;
      S_CLOSE: if (ras_ok) nx = S_PRE;
      S_PRE:   if (tmr == TW'(RP_CYC - 1))
                 nx = (!initd || ref_due) ? S_REFC : (op_pend ? S_ACT : S_IDLE);
      S_REFC:  nx = S_REFR;
      S_REFR:  if (ras_ok) nx = S_PRE;
      default: nx = S_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PWR; tmr <= '0; ras_cnt <= '0; ref_tmr <= '0; pend <= '0; wake <= '0;
      initd <= 1'b0; op_pend <= 1'b0; op_we <= 1'b0; op_row <= '0; op_col <= '0;
      op_wd <= '0; rdata <= '0; rvalid <= 1'b0;
    end else begin
      st  <= nx;
      tmr <= (nx != st) ? '0 : tmr + 1'b1;
      if (dram_ras_n) ras_cnt <= '0;
      else if (!ras_ok) ras_cnt <= ras_cnt + 1'b1;
      if (accept) begin
        op_row  <= addr[AW-1:COL_W];
        op_col  <= addr[COL_W-1:0];
        op_we   <= we;
        op_wd   <= wdata;
        op_pend <= 1'b1;
      end else if (cas_end) op_pend <= 1'b0;
      rvalid <= cas_end && !op_we;
      if (cas_end && !op_we) rdata <= dq_in;
      if (ref_end && !initd) begin
        if (wake == WW'(WAKE_CYCLES - 1)) initd <= 1'b1;
        else wake <= wake + 1'b1;
      end
      if (initd) ref_tmr <= tick ? '0 : ref_tmr + 1'b1;
      if (tick && !(ref_end && initd) && pend != PW'(MAX_PEND)) pend <= pend + 1'b1;
      else if (!tick && ref_end && initd) pend <= pend - 1'b1;
    end
  end

  AST_RAS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> $past(ras_cnt) == RCW'(RAS_CYC - 1)); // R7
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) && !dram_cas_n |-> $past(!dram_cas_n)); // R8
  AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) && !dram_ras_n && !dram_we_n |-> $past(dq_oe) && dq_oe); // R4
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R5
  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !initd |-> dram_we_n && dram_oe_n && !dq_oe); // R2
  AST_PEND_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PEND)); // R8
endmodule

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 12, COL_W = 10, DQ_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [ROW_W+COL_W-1:0] addr = '0;
  logic [DQ_W-1:0] wdata = '0, rdata, dq_out, dq_in = '0;
  logic ready, rvalid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dq_oe;
  logic [ROW_W-1:0] dram_a;

  fpm_dram_ctrl #(.CLK_NS(CLK_PERIOD)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_a(dram_a), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, n_act = 0, n_cbr = 0, n_rv = 0, n_rd = 0;
  bit mon_on = 1'b0, first_seen = 1'b0, done = 1'b0;
  realtime t_rf = -1000.0, t_rr = -1000.0, t_cr = -1000.0, t_addr = 0.0, t_first = 0.0;
  realtime t_fall, t_valid;
  logic [ROW_W-1:0] m_row = '0, acc_row = '0;
  logic [COL_W-1:0] acc_col = '0;
  logic [DQ_W-1:0] acc_wd = '0;
  logic [DQ_W-1:0] mem [256];
  logic [7:0] idx;
  int last_row = -1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int r, input int c, input int p);
    return 4'((r * 3 + c * 5 + p * 7) & 15);
  endfunction

  function automatic realtime rmax(input realtime a, input realtime b);
    return (a > b) ? a : b;
  endfunction

  always @(dram_a) t_addr = $realtime;
  always @(negedge clk) if (rvalid) n_rv++;

  always @(negedge dram_ras_n) if (mon_on) begin
    if (!first_seen) begin first_seen = 1'b1; t_first = $realtime; end
    check($realtime - t_rr >= 30.0, "R7 tRP", int'($realtime - t_rr), 30);
    check($realtime - t_rf >= 84.0, "R7 tRC", int'($realtime - t_rf), 84);
    t_rf = $realtime;
    if (!dram_cas_n) begin
      n_cbr++;
      #1;
      check(!dq_oe && dram_oe_n, "R8 refresh drives no data", int'(dq_oe), 0);
      check(!ready, "R8 ready low in refresh", int'(ready), 0);
    end else begin
      n_act++;
      #1;
      m_row = dram_a;
      check(dram_a == acc_row, "R3 row address", int'(dram_a), int'(acc_row));
    end
  end

  always @(posedge dram_ras_n) if (mon_on) begin
    check($realtime - t_rf >= 50.0, "R7 tRAS", int'($realtime - t_rf), 50);
    t_rr = $realtime;
  end

  always @(posedge dram_cas_n) if (mon_on) t_cr = $realtime;

  always @(negedge dram_cas_n) if (mon_on && !dram_ras_n) begin
    t_fall = $realtime;
    check(t_fall - t_cr >= 10.0, "R10 tCP", int'(t_fall - t_cr), 10);
    #1;
    check(dram_a == ROW_W'(acc_col), "R3 column address", int'(dram_a), int'(acc_col));
    idx = {m_row[3:0], dram_a[3:0]};
    if (!dram_we_n) begin
      check(dq_oe && dq_out == acc_wd, "R4 write data driven", int'(dq_out), int'(acc_wd));
      mem[idx] = dq_out;
    end else begin
      check(!dram_oe_n, "R5 output enable", int'(dram_oe_n), 0);
      dq_in = ~mem[idx];
      t_valid = rmax(rmax(t_rf + 50.0, t_fall + 13.0), t_addr + 25.0);
      if (t_valid > $realtime) #(t_valid - $realtime);
      if (!dram_cas_n) dq_in = mem[idx];
    end
  end

  task automatic access(input bit w, input int r, input int c, input logic [3:0] d,
                        output logic [3:0] q);
    @(negedge clk);
    req = 1'b1; we = w; addr = {ROW_W'(r), COL_W'(c)}; wdata = d;
    while (!ready) @(negedge clk);
    acc_row = ROW_W'(r); acc_col = COL_W'(c); acc_wd = d;
    @(negedge clk);
    req = 1'b0;
    if (r != last_row) check(!ready, "R7 ready low on row change", int'(ready), 0);
    last_row = r;
    q = 'x;
    if (!w) begin
      n_rd++;
      while (!rvalid) @(negedge clk);
      q = rdata;
      @(negedge clk);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [3:0] q;
    int a0, c0;
    realtime t_rst;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    t_rst = $realtime;
    // R1: quiet, not ready, during the power-on pause
    repeat (100) @(negedge clk);
    check(!ready && dram_ras_n && dram_cas_n, "R1 quiet early", int'(ready), 0);
    repeat (19000) @(negedge clk);
    check(!ready && n_act + n_cbr == 0, "R1 quiet late", n_act + n_cbr, 0);
    while (!ready) @(negedge clk);
    check(t_first - t_rst >= 200000.0, "R1 pause length", int'(t_first - t_rst), 200000);
    check(n_cbr == 8, "R2 wake-up cycles", n_cbr, 8);
    check(n_act == 0, "R2 no activation before ready", n_act, 0);

    // R6: row-major writes and reads, page hits
    for (int r = 0; r < 4; r++) begin
      a0 = n_act; c0 = n_cbr;
      for (int c = 0; c < 8; c++) access(1'b1, r, c, pat(r, c, 0), q);
      repeat (10) @(negedge clk);
      check(n_act - a0 <= 1 + n_cbr - c0, "R6 page hits write", n_act - a0, 1 + n_cbr - c0);
    end
    for (int r = 0; r < 4; r++) begin
      a0 = n_act; c0 = n_cbr;
      for (int c = 0; c < 8; c++) begin
        access(1'b0, r, c, 4'h0, q);
        check(q == pat(r, c, 0), "R5 read data page", int'(q), int'(pat(r, c, 0)));
      end
      check(n_act - a0 <= 1 + n_cbr - c0, "R6 page hits read", n_act - a0, 1 + n_cbr - c0);
    end

    // R7: column-major order, every access changes row
    a0 = n_act;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++) access(1'b1, r, c, pat(r, c, 1), q);
    repeat (20) @(negedge clk);
    check(n_act - a0 == 32, "R7 miss reactivates", n_act - a0, 32);
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++) begin
        access(1'b0, r, c, 4'h0, q);
        check(q == pat(r, c, 1), "R5 read data miss", int'(q), int'(pat(r, c, 1)));
      end

    // R3: extreme address
    access(1'b1, 12'hFFF, 10'h3FF, 4'h6, q);
    access(1'b0, 12'hFFF, 10'h3FF, 4'h0, q);
    check(q == 4'h6, "R3 top address data", int'(q), 6);

    // R9: refresh with a page open
    access(1'b1, 2, 3, 4'hA, q);
    c0 = n_cbr;
    repeat (1700) @(negedge clk);
    check(dram_ras_n == 1'b1, "R9 page closed", int'(dram_ras_n), 1);
    check(n_cbr > c0, "R9 refresh ran", n_cbr - c0, 1);
    a0 = n_act;
    access(1'b0, 2, 3, 4'h0, q);
    check(q == 4'hA, "R9 data after refresh", int'(q), 10);
    check(n_act - a0 == 1, "R9 row reopened", n_act - a0, 1);

    // R8: refresh rate over 200 us of idle
    c0 = n_cbr;
    repeat (20000) @(negedge clk);
    check(n_cbr - c0 >= 12 && n_cbr - c0 <= 13, "R8 refresh rate", n_cbr - c0, 12);

    check(n_rv == n_rd, "R5 one valid pulse per read", n_rv, n_rd);
    finish_up();
  end
endmodule